// File: doc/BRIEF.md
# Beam Loss Difference and Sum Trip

This block compares two beam-intensity readings taken on one beam pulse, one from a current monitor upstream and one downstream, to judge how much beam was lost between them. Each reading is a 16-bit two's complement word that comes with its own one-cycle valid strobe. The two strobes may arrive in the same cycle or in either order. Once both halves of a pair are captured, the block forms the magnitude of their difference. It checks that magnitude against a per-pulse limit. It also keeps a sliding total of the last ten magnitudes and checks that total against an integrated limit.

Two difference engines with opposite operand order run side by side, and both feed the per-pulse check. Each raw reading is also tested against its own signed maximum-intensity limit. Any violation sets a trip latch that drops the active-high permit. The latch, the ten-entry history and the total are cleared by the asynchronous power-up reset or by a manual reset. An external interlock reset does the same, but only while the latch is set.

Top module: `beam_loss_trip`

## Requirements
- R1: After reset, permit_o is 1, diff_o is 0 and sum_o is 0.
- R2: A pair is evaluated once both channels have strobed, in the same cycle or in either order. diff_o shows |A-B| as a 16-bit unsigned value on the cycle after the later strobe is captured.
- R3: The |A-B| and |B-A| engines must agree, so swapping the channel values gives the same diff_o. A disagreement trips.
- R4: A pulse whose difference is strictly greater than pulse_lim_i trips. A difference equal to the limit does not trip.
- R5: sum_o equals the sum of the last ten differences. On the eleventh pulse, the oldest difference leaves the total.
- R6: A ten-pulse total strictly greater than sum_lim_i trips. A total equal to the limit does not trip.
- R7: A channel sample strictly greater than its signed maximum (a_max_i or b_max_i) trips, compared as two's complement.
- R8: Once tripped, permit_o stays 0 through later clean pulses until a reset clears it.
- R9: man_rst_i clears the trip latch, the history, sum_o and diff_o on the next clock.
- R10: ilk_rst_i clears like R9 only while tripped. When not tripped it has no effect, and sum_o keeps its value.
- R11: sum_o is 20 bits wide and holds ten worst-case differences (10 x 65535 = 655350) without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| man_rst_i | input | 1 | Manual synchronous clear |
| ilk_rst_i | input | 1 | Interlock clear, honoured only when tripped |
| a_data_i | input | 16 | Channel A sample, two's complement |
| a_valid_i | input | 1 | Channel A sample strobe |
| b_data_i | input | 16 | Channel B sample, two's complement |
| b_valid_i | input | 1 | Channel B sample strobe |
| pulse_lim_i | input | 16 | Per-pulse difference limit, unsigned |
| sum_lim_i | input | 20 | Ten-pulse total limit, unsigned |
| a_max_i | input | 16 | Channel A maximum intensity, signed |
| b_max_i | input | 16 | Channel B maximum intensity, signed |
| permit_o | output | 1 | Active-high beam permit |
| diff_o | output | 16 | Last evaluated absolute difference |
| sum_o | output | 20 | Total of the last ten differences |

## Verification
The assertions assume that each channel strobes at most once per pair, so no second strobe overwrites a sample still waiting for its partner. They also assume the limit inputs stay static while a pair is in flight. The stimulus meets both assumptions: every pair is completed before the next begins, and limits change only between pairs, when nothing is pending. Clear requests are never issued in the same cycle as a strobe. The assertions rely on this because they exclude the clear cycle.

// File: rtl/blt_pkg.sv
package blt_pkg;
  localparam int SAMPLE_W = 16;
  localparam int DEPTH    = 10;
  localparam int SUM_W    = SAMPLE_W + $clog2(DEPTH);
endpackage

// File: rtl/blt_abs_diff.sv
module blt_abs_diff #(
  parameter int W    = 16,
  parameter bit SWAP = 1'b0
) (
  input  logic signed [W-1:0] x_i,
  input  logic signed [W-1:0] y_i,
  output logic        [W-1:0] mag_o
);
  logic signed [W:0] d;
  logic signed [W:0] m;

  always_comb begin
    if (SWAP) d = {y_i[W-1], y_i} - {x_i[W-1], x_i};
    else      d = {x_i[W-1], x_i} - {y_i[W-1], y_i};
    m     = d[W] ? -d : d;
    mag_o = m[W-1:0];  // |d| <= 2^W-1 fits W bits unsigned
  end
endmodule

// File: rtl/blt_window_sum.sv
module blt_window_sum #(
  parameter int DEPTH = 10,
  parameter int DW    = 16,
  parameter int SW    = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  output logic [SW-1:0] sum_o,
  output logic [SW-1:0] sum_next_o
);
  logic [DW-1:0] taps_q [DEPTH];
  logic [SW-1:0] sum_q;

  assign sum_next_o = sum_q + SW'(din_i) - SW'(taps_q[DEPTH-1]);
  assign sum_o      = sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) taps_q[i] <= '0;
      sum_q <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < DEPTH; i++) taps_q[i] <= '0;
      sum_q <= '0;
    end else if (push_i) begin
      taps_q[0] <= din_i;
      for (int i = 1; i < DEPTH; i++) taps_q[i] <= taps_q[i-1];
      sum_q <= sum_next_o;
    end
  end

  // R9
  clr_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (sum_o == '0));

  // R10
  idle_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !push_i) |=> $stable(sum_o));
endmodule

// File: rtl/beam_loss_trip.sv
module beam_loss_trip
  import blt_pkg::*;
#(
  parameter int SW_P  = SAMPLE_W,
  parameter int DEP_P = DEPTH,
  parameter int SUM_P = SUM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              man_rst_i,
  input  logic              ilk_rst_i,
  input  logic [SW_P-1:0]   a_data_i,
  input  logic              a_valid_i,
  input  logic [SW_P-1:0]   b_data_i,
  input  logic              b_valid_i,
  input  logic [SW_P-1:0]   pulse_lim_i,
  input  logic [SUM_P-1:0]  sum_lim_i,
  input  logic [SW_P-1:0]   a_max_i,
  input  logic [SW_P-1:0]   b_max_i,
  output logic              permit_o,
  output logic [SW_P-1:0]   diff_o,
  output logic [SUM_P-1:0]  sum_o
);
  logic signed [SW_P-1:0] a_q, b_q;
  logic                   a_have_q, b_have_q;
  logic                   trip_q;
  logic [SW_P-1:0]        diff_q;
  logic [SW_P-1:0]        mag [2];
  logic [SUM_P-1:0]       sum_next;
  logic                   pair, clr;
  logic                   pulse_hit, sum_hit, int_hit, mism_hit;

  assign pair = a_have_q & b_have_q;
  assign clr  = man_rst_i | (ilk_rst_i & trip_q);

  // capture each channel independently; a pair fires once both are held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q      <= '0;
      b_q      <= '0;
      a_have_q <= 1'b0;
      b_have_q <= 1'b0;
    end else begin
      if (a_valid_i) a_q <= a_data_i;
      if (b_valid_i) b_q <= b_data_i;
      a_have_q <= a_valid_i | (a_have_q & ~pair);
      b_have_q <= b_valid_i | (b_have_q & ~pair);
    end
  end

  // opposite-order engines guard against a common-mode fault
  for (genvar g = 0; g < 2; g++) begin : g_eng
    blt_abs_diff #(.W(SW_P), .SWAP(g == 1)) u_eng (
      .x_i  (a_q),
      .y_i  (b_q),
      .mag_o(mag[g])
    );
  end

  blt_window_sum #(.DEPTH(DEP_P), .DW(SW_P), .SW(SUM_P)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .push_i    (pair),
    .din_i     (mag[0]),
    .sum_o     (sum_o),
    .sum_next_o(sum_next)
  );

  always_comb begin
    pulse_hit = (mag[0] > pulse_lim_i) | (mag[1] > pulse_lim_i);
    sum_hit   = sum_next > sum_lim_i;
    int_hit   = (a_q > $signed(a_max_i)) | (b_q > $signed(b_max_i));
    mism_hit  = mag[0] != mag[1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_q <= 1'b0;
      diff_q <= '0;
    end else if (clr) begin
      trip_q <= 1'b0;
      diff_q <= '0;
    end else if (pair) begin
      diff_q <= mag[0];
      if (pulse_hit | sum_hit | int_hit | mism_hit) trip_q <= 1'b1;
    end
  end

  assign permit_o = ~trip_q;
  assign diff_o   = diff_q;

  // R3
  eng_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair |-> (mag[0] == mag[1]));

  // R4
  pulse_trip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair && !clr && mag[0] > pulse_lim_i) |=> !permit_o);

  // R8
  trip_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!permit_o && !man_rst_i && !ilk_rst_i) |=> !permit_o);

  // R10
  ilk_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (permit_o && ilk_rst_i && !man_rst_i && !pair) |=> ($stable(sum_o) && permit_o));
endmodule

// File: tb/beam_loss_trip_tb_top.sv
`timescale 1ns/1ps
module beam_loss_trip_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        man_rst = 1'b0, ilk_rst = 1'b0;
  logic [15:0] a_d = '0, b_d = '0;
  logic        a_v = 1'b0, b_v = 1'b0;
  logic [15:0] plim = 16'd1747;
  logic [19:0] slim = 20'd5824;
  logic [15:0] amax = 16'h7fff, bmax = 16'h7fff;
  logic        permit;
  logic [15:0] diff;
  logic [19:0] sum;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  beam_loss_trip dut_i (
    .clk_i(clk), .rst_ni(rst_n), .man_rst_i(man_rst), .ilk_rst_i(ilk_rst),
    .a_data_i(a_d), .a_valid_i(a_v), .b_data_i(b_d), .b_valid_i(b_v),
    .pulse_lim_i(plim), .sum_lim_i(slim), .a_max_i(amax), .b_max_i(bmax),
    .permit_o(permit), .diff_o(diff), .sum_o(sum)
  );

  localparam int NV = 7;
  localparam int VA [NV] = '{1000, -200,  500, -1000,    0, 1200,  577};
  localparam int VB [NV] = '{ 900,  300, 2247, -1700, 1000,    0,    0};
  localparam int VD [NV] = '{ 100,  500, 1747,   700, 1000, 1200,  577};
  localparam int VS [NV] = '{ 100,  600, 2347,  3047, 4047, 5247, 5824};

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int a, input int b);
    @(negedge clk);
    a_d = 16'(a); b_d = 16'(b); a_v = 1'b1; b_v = 1'b1;
    @(negedge clk);
    a_v = 1'b0; b_v = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_split(input int a, input int b, input bit a_first);
    @(negedge clk);
    if (a_first) begin a_d = 16'(a); a_v = 1'b1; end
    else         begin b_d = 16'(b); b_v = 1'b1; end
    @(negedge clk);
    a_v = 1'b0; b_v = 1'b0;
    if (a_first) begin b_d = 16'(b); b_v = 1'b1; end
    else         begin a_d = 16'(a); a_v = 1'b1; end
    @(negedge clk);
    a_v = 1'b0; b_v = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_man();
    @(negedge clk); man_rst = 1'b1;
    @(negedge clk); man_rst = 1'b0;
  endtask

  task automatic pulse_ilk();
    @(negedge clk); ilk_rst = 1'b1;
    @(negedge clk); ilk_rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 permit", int'(permit), 1);
    check("R1 diff", int'(diff), 0);
    check("R1 sum", int'(sum), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: equal-to-limit cases for R4 and R6 included
    for (int i = 0; i < NV; i++) begin
      send(VA[i], VB[i]);
      check("R2 diff", int'(diff), VD[i]);
      check("R5 sum", int'(sum), VS[i]);
      check("R4/R6 permit at limit", int'(permit), 1);
    end

    pulse_man();
    check("R9 sum", int'(sum), 0);
    check("R9 diff", int'(diff), 0);

    // R2 order
    send_split(300, -50, 1'b1);
    check("R2 a first", int'(diff), 350);
    send_split(-40, 60, 1'b0);
    check("R2 b first", int'(diff), 100);
    // R3 swap
    send(-300, 200);
    check("R3 ab", int'(diff), 500);
    send(200, -300);
    check("R3 ba", int'(diff), 500);
    check("R3 permit", int'(permit), 1);

    // R4 pulse trip, R8 hold
    pulse_man();
    send(1748, 0);
    check("R4 trip", int'(permit), 0);
    send(0, 0);
    check("R8 held", int'(permit), 0);
    pulse_ilk();
    check("R10 clears when tripped permit", int'(permit), 1);
    check("R10 clears when tripped sum", int'(sum), 0);
    send(100, 0);
    pulse_ilk();
    check("R10 ignored sum", int'(sum), 100);
    check("R10 ignored permit", int'(permit), 1);
    pulse_man();
    check("R9 clears tripless", int'(sum), 0);

    // R5 window drop
    for (int i = 1; i <= 10; i++) send(i * 10, 0);
    check("R5 ten", int'(sum), 550);
    send(110, 0);
    check("R5 eleventh", int'(sum), 650);
    send(0, 0);
    check("R5 twelfth", int'(sum), 630);

    // R6 sum trip
    pulse_man();
    for (int i = 0; i < 3; i++) send(1500, 0);
    check("R6 below", int'(permit), 1);
    send(1500, 0);
    check("R6 trip", int'(permit), 0);
    pulse_man();
    check("R9 permit", int'(permit), 1);

    // R7 intensity
    amax = 16'd1000;
    send(1000, 1000);
    check("R7 a equal", int'(permit), 1);
    send(1001, 1001);
    check("R7 a over", int'(permit), 0);
    pulse_man();
    amax = 16'h7fff; bmax = 16'(-5);
    send(-5, -5);
    check("R7 b equal", int'(permit), 1);
    send(-4, -4);
    check("R7 b over signed", int'(permit), 0);
    pulse_man();
    bmax = 16'h7fff;

    // R11 no wrap
    plim = 16'hffff; slim = 20'hfffff;
    for (int i = 0; i < 10; i++) send(32767, -32768);
    check("R11 diff", int'(diff), 65535);
    check("R11 sum", int'(sum), 655350);
    check("R11 permit", int'(permit), 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule